// File: doc/BRIEF.md
# Banked Register File Address Sequencer

This block sits between a serial front end and the register storage of a two-port I/O expander. Each port has eight bits and eleven registers. The front end starts a transaction by presenting a start address. It then issues one read or write strobe per byte. For every byte the sequencer works out which port and which register the current pointer selects. It raises a write enable for that register, or it returns the selected register's value on the read bus. When the byte is done, the pointer either moves to the next register or stays where it is.

There are two address layouts, selected at run time:
- **Separated layout.** Each port has its own bank. Port A sits at the bottom of the map and port B sits sixteen addresses higher. Auto-increment skips the gap between the two banks and wraps after the last port B register.
- **Paired layout.** The two ports' copies of each register sit next to each other, so a pair reads as one 16-bit value.

The sequencer owns the configuration register, which both ports share. The layout select and the increment freeze are bits of that register.

Register index order within a port:
- 0 direction
- 1 input polarity
- 2 change-interrupt enable
- 3 compare value
- 4 interrupt control
- 5 shared config
- 6 pull-up
- 7 interrupt flag
- 8 interrupt capture
- 9 port value
- 10 output latch

Top module: `regmap_seq`

## Requirements
- R1: After reset the pointer is 00h and the config register is 00h. Config 00h means the separated layout with auto-increment on.
- R2: When `startValid` is high, the pointer loads `startAddr` on the next edge. Any byte strobe in that same cycle is dropped: no write enable, no config change and no advance.
- R3: Separated layout. Addresses 00h–0Ah select port A with index equal to the address. Addresses 10h–1Ah select port B with index equal to the address minus 10h. A write to a mapped non-config register raises `wrEn` combinationally, with `wrPort` (0 = A, 1 = B) and `wrIdx` set.
- R4: Paired layout. Addresses 00h–15h select port = address bit 0 and index = address shifted right by one.
- R5: Index 5 of either port is the single shared config register. It sits at 05h/15h in the separated layout and at 0Ah/0Bh in the paired layout. Writing it updates `cfgOut` and never raises `wrEn`, and reading it returns the config value.
- R6: Separated layout with increment on: a byte at 0Ah moves the pointer to 10h.
- R7: Separated layout with increment on: a byte at 1Ah moves the pointer to 00h. Other addresses step by one.
- R8: Paired layout with increment on: a byte at 15h moves the pointer to 00h. Other addresses step by one.
- R9: When config bit 5 is 1, the pointer stays unchanged after read and write bytes.
- R10: At an unmapped address, reads return 00h, and writes raise no `wrEn` and leave the config register unchanged.
- R11: Config bit 7 = 1 selects the paired layout. A config write affects decode only from the next byte on. The pointer step that follows the config write still uses the old settings.
- R12: `rdByte` combinationally shows the selected register's byte from `regValues`. Byte (port*11 + index) sits at bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Load a new start address |
| startAddr | input | 5 | Start address |
| byteWr | input | 1 | Write byte strobe |
| byteRd | input | 1 | Read byte strobe |
| wrByte | input | 8 | Write data |
| regValues | input | 176 | Current register contents, 22 bytes |
| rdByte | output | 8 | Read data for the current pointer |
| wrEn | output | 1 | Write enable to the register file |
| wrPort | output | 1 | Target port for a write |
| wrIdx | output | 4 | Target register index for a write |
| ptrOut | output | 5 | Current pointer |
| cfgOut | output | 8 | Shared config register |

## Verification
The hardest situation to reach is a config write that changes the layout or the freeze bit in the middle of a transaction. In that case the pointer step right after the write must still follow the old settings, while the next byte decodes under the new ones. Directed sequences write the config register in both layouts, with the freeze bit both set and cleared. They then check both the pointer and the decode of the following byte. Random traffic constrains writes that land on config to values that toggle only the layout and freeze bits. This keeps the layout flipping throughout a long run, so boundary addresses are crossed in both maps.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             hit;      // pointer maps to a register
    logic             port;     // 0 = port A, 1 = port B
    logic [IDX_W-1:0] idx;      // register index inside the port
    logic             isCfg;    // selected register is the shared config
    logic             doWrite;  // accepted write byte this cycle
  } strobe_t;
endpackage

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
#(
  parameter int REGS      = 11,
  parameter int STRIDE    = 16,
  parameter int CFG_IDX   = 5,
  parameter int DW        = 8,
  parameter int PAIR_BIT  = 7,
  parameter int HOLD_BIT  = 5,
  localparam int AW       = $clog2(2 * STRIDE)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic [AW-1:0] startAddr,
  input  logic          byteWr,
  input  logic          byteRd,
  input  logic [DW-1:0] wrByte,
  output strobe_t       strb,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] cfg
);
  localparam logic [AW-1:0] SepLastA  = AW'(REGS - 1);
  localparam logic [AW-1:0] SepFirstB = AW'(STRIDE);
  localparam logic [AW-1:0] SepLastB  = AW'(STRIDE + REGS - 1);
  localparam logic [AW-1:0] PairLast  = AW'(2 * REGS - 1);
  localparam logic [IDX_W-1:0] CfgIdx = IDX_W'(CFG_IDX);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(REGS - 1);

  logic pairMode, hold, adv;
  logic [AW-1:0] stepPtr;

  assign pairMode = cfg[PAIR_BIT];
  assign hold     = cfg[HOLD_BIT];
  assign adv      = (byteWr | byteRd) & ~startValid;

  // address decode for the active layout
  always_comb begin
    strb = '0;
    if (pairMode) begin
      if (ptr <= PairLast) begin
        strb.hit  = 1'b1;
        strb.port = ptr[0];
        strb.idx  = IDX_W'(ptr[AW-1:1]);
      end
    end else if (ptr[IDX_W-1:0] <= LastIdx) begin
      strb.hit  = 1'b1;
      strb.port = ptr[AW-1];
      strb.idx  = ptr[IDX_W-1:0];
    end
    strb.isCfg   = strb.hit & (strb.idx == CfgIdx);
    strb.doWrite = byteWr & ~startValid & strb.hit;
  end

  // next pointer when incrementing
  always_comb begin
    stepPtr = ptr + 1'b1;
    if (pairMode) begin
      if (ptr == PairLast) stepPtr = '0;
    end else if (ptr == SepLastA) begin
      stepPtr = SepFirstB;
    end else if (ptr == SepLastB) begin
      stepPtr = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      cfg <= '0;
    end else begin
      if (startValid)        ptr <= startAddr;
      else if (adv && !hold) ptr <= stepPtr;
      if (strb.doWrite && strb.isCfg) cfg <= wrByte;
    end
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (ptr == $past(startAddr)));
  assert_bank_jump_R6: assert property (@(posedge clk) disable iff (!rstN)
    (adv && !hold && !pairMode && ptr == SepLastA) |=> (ptr == SepFirstB));
  assert_sep_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (adv && !hold && !pairMode && ptr == SepLastB) |=> (ptr == '0));
  assert_pair_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (adv && !hold && pairMode && ptr == PairLast) |=> (ptr == '0));
  assert_hold_ptr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (adv && hold) |=> $stable(ptr));
  assert_unmapped_cfg_R10: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && !strb.hit) |=> $stable(cfg));
endmodule

// File: rtl/regmap_dp.sv
module regmap_dp
  import regmap_pkg::*;
#(
  parameter int REGS = 11,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DW-1:0]        cfg,
  input  logic [2*REGS*DW-1:0] regValues,
  output logic [DW-1:0]        rdByte,
  output logic                 wrEn,
  output logic                 wrPort,
  output logic [IDX_W-1:0]     wrIdx
);
  localparam int NumRegs = 2 * REGS;

  logic [DW-1:0] regByte [NumRegs];

  for (genvar g = 0; g < NumRegs; g++) begin : g_unpack
    assign regByte[g] = regValues[g*DW +: DW];
  end

  always_comb begin
    int sel;
    sel    = int'(strb.port) * REGS + int'(strb.idx);
    rdByte = '0;
    if (strb.hit) begin
      if (strb.isCfg)         rdByte = cfg;
      else if (sel < NumRegs) rdByte = regByte[sel];
    end
  end

  assign wrEn   = strb.doWrite & ~strb.isCfg;
  assign wrPort = strb.port;
  assign wrIdx  = strb.idx;

  assert_rd_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hit |-> (rdByte == '0));
  assert_cfg_no_wren_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.isCfg |-> !wrEn);
  assert_wren_mapped_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (strb.hit && int'(wrIdx) < REGS));
endmodule

// File: rtl/regmap_seq.sv
module regmap_seq
  import regmap_pkg::*;
#(
  parameter int REGS     = 11,
  parameter int STRIDE   = 16,
  parameter int CFG_IDX  = 5,
  parameter int DW       = 8,
  parameter int PAIR_BIT = 7,
  parameter int HOLD_BIT = 5,
  localparam int AW      = $clog2(2 * STRIDE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [AW-1:0]        startAddr,
  input  logic                 byteWr,
  input  logic                 byteRd,
  input  logic [DW-1:0]        wrByte,
  input  logic [2*REGS*DW-1:0] regValues,
  output logic [DW-1:0]        rdByte,
  output logic                 wrEn,
  output logic                 wrPort,
  output logic [IDX_W-1:0]     wrIdx,
  output logic [AW-1:0]        ptrOut,
  output logic [DW-1:0]        cfgOut
);
  strobe_t strb;

  regmap_ctrl #(
    .REGS(REGS), .STRIDE(STRIDE), .CFG_IDX(CFG_IDX), .DW(DW),
    .PAIR_BIT(PAIR_BIT), .HOLD_BIT(HOLD_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteWr(byteWr), .byteRd(byteRd), .wrByte(wrByte),
    .strb(strb), .ptr(ptrOut), .cfg(cfgOut)
  );

  regmap_dp #(.REGS(REGS), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfgOut),
    .regValues(regValues), .rdByte(rdByte), .wrEn(wrEn),
    .wrPort(wrPort), .wrIdx(wrIdx)
  );
endmodule

// File: tb/regmap_seq_tb_top.sv
`timescale 1ns/1ps
module regmap_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [4:0] startAddr = '0;
  logic byteWr = 1'b0, byteRd = 1'b0;
  logic [7:0] wrByte = '0;
  logic [175:0] regValues = '0;
  logic [7:0] rdByte, cfgOut;
  logic wrEn, wrPort;
  logic [3:0] wrIdx;
  logic [4:0] ptrOut;

  int chkCnt = 0, errCnt = 0;
  bit done = 1'b0;
  logic [4:0] expPtr;
  logic [7:0] expCfg;

  always #2 clk = ~clk;

  regmap_seq dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteWr(byteWr), .byteRd(byteRd), .wrByte(wrByte), .regValues(regValues),
    .rdByte(rdByte), .wrEn(wrEn), .wrPort(wrPort), .wrIdx(wrIdx),
    .ptrOut(ptrOut), .cfgOut(cfgOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns {hit, port, idx[3:0]}
  function automatic logic [5:0] decodeExp(input logic [4:0] p, input logic [7:0] c);
    int a = int'(p);
    if (c[7]) return (a < 22) ? {1'b1, 1'(a % 2), 4'(a / 2)} : 6'd0;
    return ((a % 16) < 11) ? {1'b1, 1'(a / 16), 4'(a % 16)} : 6'd0;
  endfunction

  function automatic logic [4:0] nextExp(input logic [4:0] p, input logic [7:0] c);
    if (c[5]) return p;
    if (c[7]) return (p == 5'h15) ? 5'h00 : p + 5'd1;
    if (p == 5'h0A) return 5'h10;
    if (p == 5'h1A) return 5'h00;
    return p + 5'd1;
  endfunction

  function automatic logic [7:0] rdExp(input logic [4:0] p, input logic [7:0] c);
    logic [5:0] d = decodeExp(p, c);
    if (!d[5]) return 8'h00;
    if (d[3:0] == 4'd5) return c;
    return regValues[(int'(d[4]) * 11 + int'(d[3:0])) * 8 +: 8];
  endfunction

  // one byte: drive at negedge, check comb outputs, model the edge
  task automatic doByte(input bit isWr, input logic [7:0] data);
    logic [5:0] d;
    string tg;
    @(negedge clk);
    byteWr = isWr; byteRd = !isWr; wrByte = data;
    #1;
    d  = decodeExp(expPtr, expCfg);
    tg = !d[5] ? "R10" : (d[3:0] == 4'd5) ? "R5" : expCfg[7] ? "R4" : "R3";
    chk({tg, " ptr"}, int'(ptrOut), int'(expPtr));
    chk({tg, " wrEn"}, int'(wrEn), int'(isWr && d[5] && d[3:0] != 4'd5));
    if (isWr && d[5] && d[3:0] != 4'd5)
      chk({tg, " target"}, int'({wrPort, wrIdx}), int'(d[4:0]));
    if (!isWr) chk({tg, " R12 rdByte"}, int'(rdByte), int'(rdExp(expPtr, expCfg)));
    @(posedge clk);
    expPtr = nextExp(expPtr, expCfg);
    if (isWr && d[5] && d[3:0] == 4'd5) expCfg = data;
    #1;
    byteWr = 1'b0; byteRd = 1'b0;
  endtask

  task automatic doStart(input logic [4:0] a, input bit withWr);
    @(negedge clk);
    startValid = 1'b1; startAddr = a; byteWr = withWr; wrByte = 8'hFF;
    #1;
    if (withWr) chk("R2 wrEn dropped", int'(wrEn), 0);
    @(posedge clk);
    expPtr = a;
    #1;
    startValid = 1'b0; byteWr = 1'b0;
    if (withWr) chk("R2 cfg untouched", int'(cfgOut), int'(expCfg));
  endtask

  task automatic randRegs();
    for (int i = 0; i < 6; i++) regValues[i*32 +: 32] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chkCnt++; errCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    randRegs();
    expPtr = '0; expCfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 ptr", int'(ptrOut), 0);
    chk("R1 cfg", int'(cfgOut), 0);
    chk("R1 wrEn", int'(wrEn), 0);

    doStart(5'h05, 1'b0); doByte(1'b0, 8'h00);          // R5 cfg read in separated
    doStart(5'h09, 1'b0); doByte(1'b0, 8'h00); doByte(1'b0, 8'h00);
    chk("R6 jump", int'(ptrOut), 16);
    doStart(5'h19, 1'b0); doByte(1'b1, 8'h3C); doByte(1'b0, 8'h00);
    chk("R7 wrap", int'(ptrOut), 0);
    doStart(5'h0C, 1'b0); doByte(1'b1, 8'h55);            // R10 unmapped write
    chk("R10 cfg", int'(cfgOut), 0);
    doStart(5'h04, 1'b1);                                   // R2 start wins
    chk("R2 ptr", int'(ptrOut), 4);
    doStart(5'h15, 1'b0); doByte(1'b1, 8'h80);            // R11 switch to paired
    chk("R11 old step", int'(ptrOut), 22);
    doByte(1'b0, 8'h00);                                    // 16h unmapped in paired
    doStart(5'h0A, 1'b0); doByte(1'b0, 8'h00);            // R5 cfg at 0Ah
    doStart(5'h14, 1'b0); doByte(1'b0, 8'h00); doByte(1'b0, 8'h00);
    chk("R8 wrap", int'(ptrOut), 0);
    doStart(5'h0B, 1'b0); doByte(1'b1, 8'hA0);            // paired + hold
    chk("R11 step before hold", int'(ptrOut), 12);
    doStart(5'h13, 1'b0);
    for (int i = 0; i < 3; i++) doByte(1'b1, 8'(i));
    chk("R9 hold", int'(ptrOut), 19);
    doStart(5'h0A, 1'b0); doByte(1'b1, 8'h00);
    chk("R11 hold applies to own step", int'(ptrOut), 10);
    doByte(1'b0, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 2) begin
        if ($urandom_range(0, 3) == 0) randRegs();
        doStart(5'($urandom), $urandom_range(0, 4) == 0);
      end else if (r < 6) begin
        doByte(1'b0, 8'h00);
      end else begin
        logic [5:0] d = decodeExp(expPtr, expCfg);
        if (d[5] && d[3:0] == 4'd5) doByte(1'b1, 8'($urandom) & 8'hA0);
        else doByte(1'b1, 8'($urandom));
      end
    end
    #1;
    chk("R11 final cfg", int'(cfgOut), int'(expCfg));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  end
endmodule